// File: doc/BRIEF.md
# Sinc3 and Sinc1 Cascade Decimator

This block turns the single-bit output of a delta-sigma modulator into 24-bit signed conversion results. It receives one bit per clock. A third-order comb-integrator stage does the main decimation. For the higher oversampling ratios, a first-order averaging stage follows it and adds the rest of the decimation. A 4-bit select input picks an overall ratio that is a power of two from 64 to 16384.

Every result is delivered with a one-cycle ready strobe. Results keep flowing while the filter is still settling. A separate settled flag tells the consumer when the results can be trusted. The flag drops, and the settling count starts again, after reset, after a resync pulse, and after any change of the select input. Each of these events also clears all filter state in the same clock cycle.

Top module: `sinc_decimator`

## Requirements
- R1: Select code c (0 to 8) gives an overall ratio of 64·2^c. Codes 9 to 15 behave as code 8 (16384). In steady operation the ready strobe fires once every ratio clocks.
- R2: For codes 0 to 4 only the third-order stage runs, at the full ratio. A constant 1 input settles to +4194304 (0x400000) and a constant 0 input settles to -4194304 (0xC00000).
- R3: For codes 5 to 8 the third-order stage runs at 1024. The averaging stage then sums N = 2^(c-4) of its results. The output uses the same full-scale scaling as R2.
- R4: The result is 24-bit two's complement and equals (2d-1)·4194304, where d is the input ones density. An input of 1,0,1,0… settles to 0 and an input of three ones per four bits settles to 2097152.
- R5: In third-order-only mode, settled goes high exactly 4·ratio + 48 clocks after the clearing edge. This is the settling time plus one conversion.
- R6: In cascaded mode with averaging factor N, settled goes high exactly (3N+2)·1024 + 48 clocks after the clearing edge.
- R7: If resync is high at a clock edge, all filter state is cleared and settled is low after that edge. Settling is then counted again from zero, including when the pulse arrives in the middle of a settling period.
- R8: A change of the select input clears the state and restarts settling in the same way as resync.
- R9: The ready strobe is a single-cycle pulse and also fires before settled is high. The result register changes only in the cycle where the strobe is high.
- R10: While reset is active, result, ready and settled are all 0. Settling is counted from the release of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_bit | input | 1 | Modulator bit: 1 counts as +1, 0 counts as -1 |
| osr_sel | input | 4 | Oversampling ratio select code |
| resync | input | 1 | Clears filter state and restarts settling |
| result | output | 24 | Signed conversion result |
| drdy | output | 1 | One-cycle pulse when result updates |
| settled | output | 1 | High once results are valid |

## Verification
The hardest state to reach is the highest ratio with the averaging stage at its largest factor. Settling there takes more than fifty thousand clocks, and the select value that produces it is an out-of-range code. The stimulus table drives code 15 with a constant input and runs the full settling period. This checks the clamp, the cascaded settling formula, the strobe spacing and the steady value in one long entry. Periodic input patterns whose period divides every ratio give exact steady results, so the bench can compare bit for bit. Resync and select changes are applied while the flag is high and again in the middle of settling, to show that the count restarts.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
    localparam int SEL_W      = 4;
    localparam int SEL_MAX    = 8;
    localparam int BASE_LOG   = 6;
    localparam int K3_MAX     = 10;
    localparam int N1_LOG_MAX = 4;
    localparam int FIXED_LAT  = 48;
    localparam int OUT_W      = 24;
    localparam int ACC3_W     = 3 * K3_MAX + 2;
    localparam int ACC1_W     = ACC3_W + N1_LOG_MAX;
    localparam int K3_W       = $clog2(K3_MAX + 1);
    localparam int N1_W       = $clog2(N1_LOG_MAX + 1);
    localparam int G_W        = $clog2(3 * K3_MAX + N1_LOG_MAX + 1);
    localparam int SET_W      = 17;
    localparam int MIN_GAIN   = 3 * BASE_LOG;

    typedef struct packed {
        logic [K3_W-1:0] k3;
        logic [N1_W-1:0] n1log;
        logic [G_W-1:0]  gain_log;
    } osr_cfg_t;

    function automatic osr_cfg_t decode_osr(input logic [SEL_W-1:0] sel);
        osr_cfg_t c;
        int s;
        int l;
        int k;
        s = (int'(sel) > SEL_MAX) ? SEL_MAX : int'(sel);
        l = BASE_LOG + s;
        k = (l > K3_MAX) ? K3_MAX : l;
        c.k3       = K3_W'(k);
        c.n1log    = N1_W'(l - k);
        c.gain_log = G_W'(3 * k + (l - k));
        return c;
    endfunction

    function automatic logic [SET_W-1:0] settle_target(input osr_cfg_t c);
        int r;
        if (c.n1log == '0)
            r = 4 * (1 << c.k3) + FIXED_LAT;
        else
            r = (3 * (1 << c.n1log) + 2) * (1 << K3_MAX) + FIXED_LAT;
        return SET_W'(r);
    endfunction
endpackage

// File: rtl/sdf_sinc3.sv
module sdf_sinc3 #(
    parameter int W      = sdf_pkg::ACC3_W,
    parameter int K3_MAX = sdf_pkg::K3_MAX,
    localparam int KW    = $clog2(K3_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic [KW-1:0]       k3,
    input  logic                din,
    output logic signed [W-1:0] dout,
    output logic                dout_vld
);
    typedef struct packed {
        logic signed [W-1:0] i1;
        logic signed [W-1:0] i2;
        logic signed [W-1:0] i3;
        logic signed [W-1:0] z1;
        logic signed [W-1:0] z2;
        logic signed [W-1:0] z3;
        logic [K3_MAX-1:0]   dcnt;
        logic signed [W-1:0] y;
        logic                vld;
    } s3_t;

    s3_t q, d;

    always_comb begin
        logic signed [W-1:0] x;
        logic signed [W-1:0] t1;
        logic signed [W-1:0] t2;
        logic [K3_MAX:0]     one_sh;
        logic [K3_MAX-1:0]   dmask;
        d      = q;
        d.vld  = 1'b0;
        x      = din ? W'(1) : '1;
        one_sh = (K3_MAX + 1)'(1) << k3;
        dmask  = K3_MAX'(one_sh - 1'b1);
        d.i1   = q.i1 + x;
        d.i2   = q.i2 + q.i1;
        d.i3   = q.i3 + q.i2;
        t1     = q.i3 - q.z1;
        t2     = t1 - q.z2;
        if (q.dcnt == dmask) begin
            d.dcnt = '0;
            d.z1   = q.i3;
            d.z2   = t1;
            d.z3   = t2;
            d.y    = t2 - q.z3;
            d.vld  = 1'b1;
        end else begin
            d.dcnt = q.dcnt + 1'b1;
        end
        if (clr)
            d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout     = q.y;
    assign dout_vld = q.vld;

    AST_S3_SINGLE_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        q.vld |=> !q.vld); // R9
endmodule

// File: rtl/sdf_sinc1.sv
module sdf_sinc1 #(
    parameter int IN_W       = sdf_pkg::ACC3_W,
    parameter int W          = sdf_pkg::ACC1_W,
    parameter int N1_LOG_MAX = sdf_pkg::N1_LOG_MAX,
    localparam int NW        = $clog2(N1_LOG_MAX + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic [NW-1:0]          n1log,
    input  logic signed [IN_W-1:0] din,
    input  logic                   din_vld,
    output logic signed [W-1:0]    dout,
    output logic                   dout_vld
);
    typedef struct packed {
        logic signed [W-1:0]   acc;
        logic [N1_LOG_MAX-1:0] cnt;
        logic signed [W-1:0]   y;
        logic                  vld;
    } s1_t;

    s1_t q, d;
    logic [N1_LOG_MAX-1:0] nmask;

    always_comb begin
        logic [N1_LOG_MAX:0] one_sh;
        one_sh = (N1_LOG_MAX + 1)'(1) << n1log;
        nmask  = N1_LOG_MAX'(one_sh - 1'b1);
    end

    always_comb begin
        logic signed [W-1:0] ext;
        d     = q;
        d.vld = 1'b0;
        ext   = {{(W - IN_W){din[IN_W-1]}}, din};
        if (din_vld) begin
            if (q.cnt == nmask) begin
                d.y   = q.acc + ext;
                d.acc = '0;
                d.cnt = '0;
                d.vld = 1'b1;
            end else begin
                d.acc = q.acc + ext;
                d.cnt = q.cnt + 1'b1;
            end
        end
        if (clr)
            d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout     = q.y;
    assign dout_vld = q.vld;

    AST_S1_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= nmask); // R3
endmodule

// File: rtl/sdf_settle.sv
module sdf_settle #(
    parameter int SET_W = sdf_pkg::SET_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SET_W-1:0] target,
    output logic             settled
);
    typedef struct packed {
        logic [SET_W-1:0] cnt;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        if (q.cnt != target)
            d.cnt = q.cnt + 1'b1;
        if (clr)
            d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign settled = (q.cnt == target);

    AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= target); // R5
    AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        settled && !clr |=> settled); // R7
endmodule

// File: rtl/sinc_decimator.sv
module sinc_decimator #(
    parameter int OUT_W = sdf_pkg::OUT_W,
    parameter int SEL_W = sdf_pkg::SEL_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mod_bit,
    input  logic [SEL_W-1:0]        osr_sel,
    input  logic                    resync,
    output logic signed [OUT_W-1:0] result,
    output logic                    drdy,
    output logic                    settled
);
    import sdf_pkg::*;

    localparam int PAD = OUT_W - 2 - MIN_GAIN;

    typedef struct packed {
        logic [SEL_W-1:0]        osr;
        logic signed [OUT_W-1:0] result;
        logic                    drdy;
    } top_t;

    top_t q, d;
    osr_cfg_t cfg;
    logic clr;
    logic signed [ACC3_W-1:0] s3_y;
    logic s3_vld;
    logic signed [ACC1_W-1:0] s1_y;
    logic s1_vld;

    assign cfg = decode_osr(q.osr);
    assign clr = resync || (osr_sel != q.osr);

    sdf_sinc3 #(.W(ACC3_W), .K3_MAX(K3_MAX)) u_sinc3 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .k3(cfg.k3),
        .din(mod_bit), .dout(s3_y), .dout_vld(s3_vld)
    );

    sdf_sinc1 #(.IN_W(ACC3_W), .W(ACC1_W), .N1_LOG_MAX(N1_LOG_MAX)) u_sinc1 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .n1log(cfg.n1log),
        .din(s3_y), .din_vld(s3_vld), .dout(s1_y), .dout_vld(s1_vld)
    );

    sdf_settle #(.SET_W(SET_W)) u_settle (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .target(settle_target(cfg)), .settled(settled)
    );

    always_comb begin
        logic signed [ACC1_W+PAD-1:0] w;
        logic [G_W-1:0] sh;
        d      = q;
        d.osr  = osr_sel;
        d.drdy = s1_vld;
        sh     = cfg.gain_log - G_W'(MIN_GAIN);
        w      = {s1_y, {PAD{1'b0}}};
        w      = w >>> sh;
        if (s1_vld)
            d.result = OUT_W'(w);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign result = q.result;
    assign drdy   = q.drdy;

    AST_DRDY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        drdy |=> !drdy); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !drdy |-> $stable(result)); // R9
    AST_CLR_UNSETTLES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !settled); // R7
    AST_OSR_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (osr_sel != q.osr) |=> !settled); // R8
endmodule

// File: tb/tb_sinc_decimator.sv
module tb_sinc_decimator;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG = 190000;
    localparam int NV = 8;
    localparam logic [5:0] VEC [NV] = '{
        {4'd0, 2'd0}, {4'd1, 2'd1}, {4'd2, 2'd2}, {4'd3, 2'd3},
        {4'd4, 2'd0}, {4'd5, 2'd1}, {4'd6, 2'd3}, {4'd15, 2'd0}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic mod_bit = 0;
    logic [3:0] osr_sel = 0;
    logic resync = 0;
    logic signed [23:0] result;
    logic drdy;
    logic settled;
    logic [1:0] pat = 0;
    logic [1:0] ph = 0;
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    sinc_decimator dut (
        .clk(clk), .rst_n(rst_n), .mod_bit(mod_bit), .osr_sel(osr_sel),
        .resync(resync), .result(result), .drdy(drdy), .settled(settled)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // pattern 0: all ones, 1: all zeros, 2: alternating, 3: three of four ones
    always @(negedge clk) begin
        ph <= ph + 2'd1;
        case (pat)
            2'd0: mod_bit <= 1'b1;
            2'd1: mod_bit <= 1'b0;
            2'd2: mod_bit <= ph[0];
            default: mod_bit <= (ph != 2'd0);
        endcase
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            errors++;
            $display("FAIL watchdog R1: actual %0d cycles expected below %0d", cyc, WDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic int exp_osr(input int sel);
        return 64 << ((sel > 8) ? 8 : sel);
    endfunction

    function automatic int exp_target(input int sel);
        int o;
        o = exp_osr(sel);
        if (o <= 1024) return 4 * o + 48;
        return (3 * (o / 1024) + 2) * 1024 + 48;
    endfunction

    function automatic int exp_res(input logic [1:0] p);
        case (p)
            2'd0: return 4194304;
            2'd1: return -4194304;
            2'd2: return 0;
            default: return 2097152;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_settled(output int n, output int pulses);
        n = 0;
        pulses = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (drdy) pulses++;
        end while (!settled && n < 60000);
    endtask

    task automatic pulse_resync();
        @(negedge clk);
        resync = 1'b1;
        @(posedge clk);
        @(negedge clk);
        resync = 1'b0;
    endtask

    task automatic wait_drdy(output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!drdy && n < 40000);
    endtask

    initial begin
        int n;
        int p;
        // R10 reset state
        repeat (3) @(negedge clk);
        chk("R10 result", int'(result), 0);
        chk("R10 drdy", int'(drdy), 0);
        chk("R10 settled", int'(settled), 0);
        rst_n = 1'b1;
        wait_settled(n, p);
        chk("R10 settle from reset", n, exp_target(0));

        for (int v = 0; v < NV; v++) begin
            int sel;
            logic [1:0] pt;
            sel = int'(VEC[v][5:2]);
            pt  = VEC[v][1:0];
            @(negedge clk);
            osr_sel = VEC[v][5:2];
            pat = pt;
            resync = 1'b1;
            @(posedge clk);
            @(negedge clk);
            resync = 1'b0;
            wait_settled(n, p);
            chk((sel < 5) ? "R5 settle" : "R6 settle", n, exp_target(sel));
            chk("R9 strobes before settled", int'(p > 0), 1);
            wait_drdy(n);
            chk((pt >= 2) ? "R4 value" : ((sel < 5) ? "R2 value" : "R3 value"),
                int'(result), exp_res(pt));
            wait_drdy(n);
            chk("R1 strobe spacing", n, exp_osr(sel));
            chk("R4 repeat value", int'(result), exp_res(pt));
        end

        // R8: select change after settling restarts it
        @(negedge clk);
        pat = 2'd0;
        osr_sel = 4'd0;
        @(posedge clk);
        @(negedge clk);
        chk("R8 settled drops", int'(settled), 0);
        wait_settled(n, p);
        chk("R8 settle restart", n, exp_target(0));

        // R7: resync while settled
        pulse_resync();
        chk("R7 settled drops", int'(settled), 0);
        wait_settled(n, p);
        chk("R7 settle restart", n, exp_target(0));

        // R7: resync in the middle of settling restarts the count
        pulse_resync();
        repeat (100) @(negedge clk);
        chk("R7 mid settle low", int'(settled), 0);
        pulse_resync();
        wait_settled(n, p);
        chk("R7 mid settle restart", n, exp_target(0));
        wait_drdy(n);
        chk("R2 after restart", int'(result), 4194304);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule